// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block is the hazard control of a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. It looks at the opcodes, register IDs, branch outcome and status codes held in the pipeline registers. From these it drives one stall or bubble strobe per pipeline register, and an enable for the condition-code register. It is purely combinational, so its strobes apply at the next clock edge of the surrounding pipeline. Forwarding and the datapath are handled elsewhere.

The block handles four situations, and more than one can be present at once:
- A return in flight holds fetch until the return has cleared the memory stage.
- A load whose result is needed by the next instruction costs one stall cycle.
- A conditional jump that was predicted taken but not taken has its two wrong-path instructions squashed.
- A faulting instruction freezes the later stages, so nothing after it alters architectural state.

Top module: `pipeHazardCtrl`

## Requirements
- R1: Opcodes are 4-bit values: 0 halt, 1 nop, 2 conditional move, 3 immediate move, 4 store, 5 load, 6 ALU op, 7 jump, 8 call, 9 return, 10 push, 11 pop. Status 1 means normal; any other status value is an exception. With no hazard and no exception, every stall and bubble output is 0.
- R2: A load/use hazard exists when execute holds a load (5) or pop (11) whose memory destination ID equals the decode source A ID or the decode source B ID. The ID 15 means "no register" and never produces a match.
- R3: On a load/use hazard, fStall=1, dStall=1 and eBubble=1.
- R4: When a return (9) sits in decode, execute or memory, fStall=1 and, unless R5 applies, dBubble=1.
- R5: When a load/use hazard and a pending return occur together, decode is stalled (dStall=1) and not bubbled (dBubble=0).
- R6: When execute holds a jump (7) with eCnd=0, dBubble=1 and eBubble=1. This alone does not raise fStall or dStall.
- R7: When mStat or wStat is an exception, mBubble=1. When wStat is an exception, wStall=1.
- R8: ccEnable=1 exactly when execute holds an ALU op (6) and neither mStat nor wStat is an exception.
- R9: Decode is never stalled and bubbled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dIcode | input | 4 | Opcode in the decode register |
| dSrcA | input | 4 | Decode source A register ID |
| dSrcB | input | 4 | Decode source B register ID |
| eIcode | input | 4 | Opcode in the execute register |
| eDstM | input | 4 | Memory-result destination ID in execute |
| eCnd | input | 1 | Branch/condition outcome computed in execute |
| mIcode | input | 4 | Opcode in the memory register |
| mStat | input | 3 | Status code in the memory register |
| wStat | input | 3 | Status code in the write-back register |
| fStall | output | 1 | Hold the fetch register (PC) |
| dStall | output | 1 | Hold the decode register |
| dBubble | output | 1 | Load a nop into the decode register |
| eBubble | output | 1 | Load a nop into the execute register |
| mBubble | output | 1 | Load a nop into the memory register |
| wStall | output | 1 | Hold the write-back register |
| ccEnable | output | 1 | Allow the condition codes to update |

## Verification
The bench builds the block with its default parameter values: 4-bit opcodes and register IDs, 3-bit status, and the opcode encodings listed in R1. With these widths, random stimulus drawn from a small set of opcodes and only a few register IDs (plus 15) often produces load/use matches, pending returns, not-taken jumps and exception statuses. Many cycles therefore combine several hazards, which exercises the priority of R5 alongside directed corner cases.

// File: rtl/pipeHazardPkg.sv
package pipeHazardPkg;
  // Hazard conditions passed from the detector to the policy logic
  typedef struct packed {
    logic loadUse;
    logic retInFlight;
    logic mispredict;
    logic excMem;
    logic excWb;
    logic aluInExec;
  } hazardFlagsT;

  // Per-register strobes delivered by the policy logic
  typedef struct packed {
    logic fStall;
    logic dStall;
    logic dBubble;
    logic eBubble;
    logic mBubble;
    logic wStall;
    logic ccEnable;
  } stageCtlT;
endpackage

// File: rtl/hazardDetect.sv
module hazardDetect
  import pipeHazardPkg::*;
#(
  parameter int OPW = 4,
  parameter int REGW = 4,
  parameter int STW = 3,
  parameter logic [OPW-1:0] OP_LOAD = 4'h5,
  parameter logic [OPW-1:0] OP_POP = 4'hB,
  parameter logic [OPW-1:0] OP_RET = 4'h9,
  parameter logic [OPW-1:0] OP_JMP = 4'h7,
  parameter logic [OPW-1:0] OP_ALU = 4'h6,
  parameter logic [STW-1:0] ST_OK = 3'd1
) (
  input  logic [OPW-1:0]  dIcode,
  input  logic [REGW-1:0] dSrcA,
  input  logic [REGW-1:0] dSrcB,
  input  logic [OPW-1:0]  eIcode,
  input  logic [REGW-1:0] eDstM,
  input  logic            eCnd,
  input  logic [OPW-1:0]  mIcode,
  input  logic [STW-1:0]  mStat,
  input  logic [STW-1:0]  wStat,
  output hazardFlagsT     flags
);
  localparam int NSRC = 2;
  localparam logic [REGW-1:0] REG_NONE = {REGW{1'b1}};

  logic [REGW-1:0] srcIds [NSRC];
  logic [NSRC-1:0] srcHit;
  logic            execIsLoad;

  assign srcIds[0] = dSrcA;
  assign srcIds[1] = dSrcB;
  assign execIsLoad = (eIcode == OP_LOAD) || (eIcode == OP_POP);

  for (genvar i = 0; i < NSRC; i++) begin : g_srcCmp
    assign srcHit[i] = (srcIds[i] != REG_NONE) && (srcIds[i] == eDstM);
  end

  always_comb begin
    flags.loadUse     = execIsLoad && (|srcHit);
    flags.retInFlight = (dIcode == OP_RET) || (eIcode == OP_RET) || (mIcode == OP_RET);
    flags.mispredict  = (eIcode == OP_JMP) && !eCnd;
    flags.excMem      = (mStat != ST_OK);
    flags.excWb       = (wStat != ST_OK);
    flags.aluInExec   = (eIcode == OP_ALU);
  end

  // A no-register destination can never raise a load/use hazard
  always_comb begin
    if (!$isunknown({eDstM, eIcode, dSrcA, dSrcB}) && eDstM == REG_NONE)
      assert_noneNeverHits_R2: assert (!flags.loadUse)
        else $error("load/use raised on the no-register ID");
  end
endmodule

// File: rtl/hazardPolicy.sv
module hazardPolicy
  import pipeHazardPkg::*;
(
  input  hazardFlagsT flags,
  output stageCtlT    ctl
);
  always_comb begin
    ctl.fStall   = flags.loadUse || flags.retInFlight;
    ctl.dStall   = flags.loadUse;
    ctl.dBubble  = flags.mispredict || (flags.retInFlight && !flags.loadUse);
    ctl.eBubble  = flags.mispredict || flags.loadUse;
    ctl.mBubble  = flags.excMem || flags.excWb;
    ctl.wStall   = flags.excWb;
    ctl.ccEnable = flags.aluInExec && !flags.excMem && !flags.excWb;
  end

  always_comb begin
    if (!$isunknown({flags, ctl})) begin
      assert_noStallBubble_R9: assert (!(ctl.dStall && ctl.dBubble))
        else $error("decode stalled and bubbled together");
      assert_loadUseFreeze_R3: assert (!ctl.dStall || (ctl.fStall && ctl.eBubble))
        else $error("decode hold without fetch hold and execute bubble");
      assert_wbFreezeDrains_R7: assert (!ctl.wStall || ctl.mBubble)
        else $error("write-back held without memory bubble");
      assert_ccBlocked_R8: assert (!ctl.ccEnable || (!flags.excMem && !flags.excWb))
        else $error("condition codes enabled behind an exception");
    end
  end
endmodule

// File: rtl/pipeHazardCtrl.sv
module pipeHazardCtrl
  import pipeHazardPkg::*;
#(
  parameter int OPW = 4,
  parameter int REGW = 4,
  parameter int STW = 3
) (
  input  logic [OPW-1:0]  dIcode,
  input  logic [REGW-1:0] dSrcA,
  input  logic [REGW-1:0] dSrcB,
  input  logic [OPW-1:0]  eIcode,
  input  logic [REGW-1:0] eDstM,
  input  logic            eCnd,
  input  logic [OPW-1:0]  mIcode,
  input  logic [STW-1:0]  mStat,
  input  logic [STW-1:0]  wStat,
  output logic            fStall,
  output logic            dStall,
  output logic            dBubble,
  output logic            eBubble,
  output logic            mBubble,
  output logic            wStall,
  output logic            ccEnable
);
  hazardFlagsT flags;
  stageCtlT    ctl;

  hazardDetect #(.OPW(OPW), .REGW(REGW), .STW(STW)) u_detect (
    .dIcode(dIcode), .dSrcA(dSrcA), .dSrcB(dSrcB),
    .eIcode(eIcode), .eDstM(eDstM), .eCnd(eCnd),
    .mIcode(mIcode), .mStat(mStat), .wStat(wStat),
    .flags(flags)
  );

  hazardPolicy u_policy (.flags(flags), .ctl(ctl));

  assign fStall   = ctl.fStall;
  assign dStall   = ctl.dStall;
  assign dBubble  = ctl.dBubble;
  assign eBubble  = ctl.eBubble;
  assign mBubble  = ctl.mBubble;
  assign wStall   = ctl.wStall;
  assign ccEnable = ctl.ccEnable;
endmodule

// File: tb/pipeHazardCtrl_tb.sv
module pipeHazardCtrl_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] dIcode, dSrcA, dSrcB, eIcode, eDstM, mIcode;
  logic       eCnd;
  logic [2:0] mStat, wStat;
  logic fStall, dStall, dBubble, eBubble, mBubble, wStall, ccEnable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pipeHazardCtrl u_dut (
    .dIcode(dIcode), .dSrcA(dSrcA), .dSrcB(dSrcB),
    .eIcode(eIcode), .eDstM(eDstM), .eCnd(eCnd),
    .mIcode(mIcode), .mStat(mStat), .wStat(wStat),
    .fStall(fStall), .dStall(dStall), .dBubble(dBubble), .eBubble(eBubble),
    .mBubble(mBubble), .wStall(wStall), .ccEnable(ccEnable)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference from the requirements, compared every cycle
  task automatic compareAll();
    int lu, rp, mp, em, ew;
    lu = ((eIcode == 5 || eIcode == 11) &&
          ((dSrcA != 15 && dSrcA == eDstM) || (dSrcB != 15 && dSrcB == eDstM))) ? 1 : 0; // R2
    rp = (dIcode == 9 || eIcode == 9 || mIcode == 9) ? 1 : 0;
    mp = (eIcode == 7 && eCnd == 0) ? 1 : 0;
    em = (mStat != 1) ? 1 : 0;
    ew = (wStat != 1) ? 1 : 0;
    chk("R3/R4 fStall", int'(fStall), (lu | rp));
    chk("R3/R5 dStall", int'(dStall), lu);
    chk("R4/R5/R6 dBubble", int'(dBubble), (mp | (rp & (1 - lu))));
    chk("R3/R6 eBubble", int'(eBubble), (mp | lu));
    chk("R7 mBubble", int'(mBubble), (em | ew));
    chk("R7 wStall", int'(wStall), ew);
    chk("R8 ccEnable", int'(ccEnable), ((eIcode == 6 && em == 0 && ew == 0) ? 1 : 0));
    chk("R9 no stall+bubble", int'(dStall & dBubble), 0);
  endtask

  task automatic drive(input int di, input int sa, input int sb, input int ei,
                       input int ed, input int c, input int mi, input int ms, input int ws);
    @(posedge clk); #1;
    dIcode = 4'(di); dSrcA = 4'(sa); dSrcB = 4'(sb); eIcode = 4'(ei);
    eDstM = 4'(ed); eCnd = 1'(c); mIcode = 4'(mi); mStat = 3'(ms); wStat = 3'(ws);
    @(negedge clk);
    compareAll();
  endtask

  function automatic int pickOp();
    int ops[7] = '{1, 6, 5, 11, 7, 9, 3};
    return ops[$urandom_range(0, 6)];
  endfunction
  function automatic int pickReg();
    return ($urandom_range(0, 4) == 0) ? 15 : int'($urandom_range(0, 3));
  endfunction
  function automatic int pickStat();
    return ($urandom_range(0, 7) == 0) ? int'($urandom_range(2, 4)) : 1;
  endfunction

  initial begin
    // R1: idle pipeline of nops, all strobes low
    drive(1, 15, 15, 1, 15, 1, 1, 1, 1);
    chk("R1 idle fStall", int'(fStall), 0);
    chk("R1 idle mBubble", int'(mBubble), 0);
    // R2: no-register ID never matches
    drive(6, 15, 15, 5, 15, 1, 1, 1, 1);
    chk("R2 none id no hazard", int'(dStall), 0);
    // R2/R3: load into reg 3, decode reads reg 3 on source B
    drive(6, 0, 3, 5, 3, 1, 1, 1, 1);
    chk("R3 load/use eBubble", int'(eBubble), 1);
    // R2: pop matching source A
    drive(6, 2, 15, 11, 2, 1, 1, 1, 1);
    chk("R2 pop hazard", int'(dStall), 1);
    // R4: return in memory
    drive(1, 15, 15, 1, 15, 1, 9, 1, 1);
    chk("R4 ret dBubble", int'(dBubble), 1);
    // R5: load/use plus return in memory
    drive(6, 4, 15, 5, 4, 1, 9, 1, 1);
    chk("R5 priority dBubble", int'(dBubble), 0);
    chk("R5 priority dStall", int'(dStall), 1);
    // R6: mispredicted jump
    drive(6, 1, 2, 7, 15, 0, 1, 1, 1);
    chk("R6 mispredict fStall", int'(fStall), 0);
    chk("R6 mispredict eBubble", int'(eBubble), 1);
    // R6: taken jump is not a mispredict
    drive(6, 1, 2, 7, 15, 1, 1, 1, 1);
    chk("R6 taken no bubble", int'(eBubble), 0);
    // R7/R8: exception in write-back blocks cc, freezes wb
    drive(1, 15, 15, 6, 15, 1, 1, 1, 3);
    chk("R7 wStall", int'(wStall), 1);
    chk("R8 cc blocked", int'(ccEnable), 0);
    // R7: exception only in memory
    drive(1, 15, 15, 6, 15, 1, 1, 4, 1);
    chk("R7 mem exc wStall", int'(wStall), 0);
    // R8: plain ALU op
    drive(1, 15, 15, 6, 15, 1, 1, 1, 1);
    chk("R8 cc enabled", int'(ccEnable), 1);
    // Random mixes
    for (int n = 0; n < 3000; n++)
      drive(pickOp(), pickReg(), pickReg(), pickOp(), pickReg(),
            int'($urandom_range(0, 1)), pickOp(), pickStat(), pickStat());
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule